// File: doc/BRIEF.md
# Flow-Controlled Transmit FIFO Filler

This block feeds a UART transmit FIFO from an upstream byte stream. When the UART reports its transmit holding register empty, the block checks the transmit-enable state and the two modem handshake inputs, clear-to-send and data-set-ready. If all of these allow it, the block runs one bounded burst. In a burst it takes bytes from the stream and pushes them into the UART FIFO, one byte per clock, until a limit is reached or the stream has nothing more to offer.

The handshake lines are checked once, when the burst starts. An end-of-stream beat on the upstream port is taken but not forwarded, and it switches the transmitter off. The block does not wait for an interrupt. Start conditions are polled on every clock while the holding register stays empty. A guard allows only one burst per empty period, so the UART FIFO is never filled twice before it drains.

Top module: `tx_burst_filler`

## Requirements
- R1: A burst starts only while the transmit-enable state (`tx_en_o`) is 1. While it is 0, no byte is taken from the stream and nothing is pushed.
- R2: A burst starts only when `cts_i` and `dsr_i` are both 1. If either is 0, the start waits and no byte moves. The two lines are not checked again during a running burst, so a drop mid-burst does not shorten it.
- R3: At most BURST_MAX bytes (default 15) are pushed per burst, at most one per clock.
- R4: A burst ends on the first clock in which it offers ready and `src_valid_i` is 0.
- R5: A beat with `src_eof_i`=1 is taken (ready and valid both high) but not pushed. It ends the burst and sets `tx_en_o` to 0 on the next clock.
- R6: After a burst has started, no new burst can start until `thre_i` has been 0 for at least one clock. Out of reset the block is armed.
- R7: While armed with `thre_i`=1, the start conditions are checked on every clock. A burst therefore starts as soon as a blocking condition clears, with no new edge needed.
- R8: A pulse on `en_set_i` sets `tx_en_o` on the next clock and a pulse on `en_clr_i` clears it. When both are high in the same clock, the clear wins.
- R9: While `rst_ni` is 0, `src_ready_o`, `fifo_push_o` and `tx_en_o` are 0.
- R10: `src_ready_o` is 1 only during a burst. A pushed byte equals `src_data_i` in the same clock, and bytes arrive in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Upstream beat valid |
| src_data_i | input | DATA_W | Upstream byte |
| src_eof_i | input | 1 | Upstream beat is an end-of-stream marker |
| src_ready_o | output | 1 | Block accepts an upstream beat |
| fifo_push_o | output | 1 | Push strobe to the UART transmit FIFO |
| fifo_data_o | output | DATA_W | Byte pushed into the UART FIFO |
| thre_i | input | 1 | UART transmit holding register empty |
| cts_i | input | 1 | Clear-to-send, active high |
| dsr_i | input | 1 | Data-set-ready, active high |
| en_set_i | input | 1 | Pulse that turns the transmitter on |
| en_clr_i | input | 1 | Pulse that turns the transmitter off |
| tx_en_o | output | 1 | Transmitter enabled state |

## Verification
The assertions assume that an upstream beat, once offered, stays stable until it is taken. They also assume that `thre_i` is a level that drops only after the FIFO has received data. The stimulus drives the stream from a queue that changes only after a completed handshake. It loads data before re-arming the holding-register flag and moves `thre_i` only between bursts. The one exception is the mid-burst handshake drop, which is the point of that test.

// File: rtl/tfill_pkg.sv
package tfill_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } fill_state_e;
endpackage

// File: rtl/tfill_arm.sv
module tfill_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thre_i,
  input  logic start_i,
  output logic armed_o
);
  logic armed_q;

  // one burst per empty period; re-armed once THRE is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b1;
    else if (start_i)  armed_q <= 1'b0;
    else if (!thre_i)  armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  AST_START_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> armed_q && thre_i) else $error("start while not armed"); // R6
endmodule

// File: rtl/tfill_enable.sv
module tfill_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic eof_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              en_q <= 1'b0;
    else if (clr_i || eof_i)  en_q <= 1'b0;
    else if (set_i)           en_q <= 1'b1;
  end

  assign en_o = en_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || eof_i) |=> !en_q) else $error("enable not cleared"); // R8
endmodule

// File: rtl/tfill_burst.sv
module tfill_burst
  import tfill_pkg::*;
#(
  parameter int BURST_MAX = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thre_i,
  input  logic armed_i,
  input  logic en_i,
  input  logic cts_i,
  input  logic dsr_i,
  input  logic src_valid_i,
  input  logic src_eof_i,
  output logic busy_o,
  output logic start_o,
  output logic push_o,
  output logic eof_take_o
);
  localparam int CNT_W = $clog2(BURST_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_MAX - 1);

  fill_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy       = (state_q == ST_BURST);
  // handshake lines are looked at only here, at the start
  assign start_o    = !busy && thre_i && armed_i && en_i && cts_i && dsr_i;
  assign push_o     = busy && src_valid_i && !src_eof_i;
  assign eof_take_o = busy && src_valid_i && src_eof_i;
  assign busy_o     = busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_o) begin
      state_d = ST_BURST;
      cnt_d   = '0;
    end else if (busy) begin
      if (!src_valid_i || src_eof_i) begin
        state_d = ST_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_BURST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt_q < CNT_W'(BURST_MAX))) else $error("burst overrun"); // R3
  AST_DRY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !src_valid_i) |=> !busy) else $error("dry burst kept running"); // R4
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(en_i && cts_i && dsr_i)) else $error("bad start"); // R2
endmodule

// File: rtl/tx_burst_filler.sv
module tx_burst_filler #(
  parameter int DATA_W    = 8,
  parameter int BURST_MAX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_eof_i,
  output logic              src_ready_o,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  input  logic              thre_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  output logic              tx_en_o
);
  logic armed, busy, start, push, eof_take, tx_en;

  tfill_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .thre_i  (thre_i),
    .start_i (start),
    .armed_o (armed)
  );

  tfill_enable u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set_i),
    .clr_i  (en_clr_i),
    .eof_i  (eof_take),
    .en_o   (tx_en)
  );

  tfill_burst #(.BURST_MAX(BURST_MAX)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thre_i      (thre_i),
    .armed_i     (armed),
    .en_i        (tx_en),
    .cts_i       (cts_i),
    .dsr_i       (dsr_i),
    .src_valid_i (src_valid_i),
    .src_eof_i   (src_eof_i),
    .busy_o      (busy),
    .start_o     (start),
    .push_o      (push),
    .eof_take_o  (eof_take)
  );

  assign src_ready_o = busy;
  assign fifo_push_o = push;
  assign fifo_data_o = src_data_i;
  assign tx_en_o     = tx_en;

  AST_EOF_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o && src_eof_i) |=> !tx_en_o) else $error("eof kept tx on"); // R5
  AST_PUSH_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> src_ready_o && src_valid_i) else $error("push outside burst"); // R10
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ready_o && !tx_en_o) |=> !src_ready_o) else $error("burst while disabled"); // R1
endmodule

// File: tb/tx_burst_filler_bench.sv
module tx_burst_filler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_valid, src_eof, src_ready, push, thre, cts, dsr, en_set, en_clr, tx_en;
  logic [7:0] src_data, push_data;

  int total = 0, bad = 0, push_cnt = 0;
  bit done = 0;
  logic [8:0] src_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] seed = 8'h10;
  bit hs;

  always #5 clk = ~clk;

  tx_burst_filler u_tx_burst_filler (
    .clk_i(clk), .rst_ni(rst_n), .src_valid_i(src_valid), .src_data_i(src_data),
    .src_eof_i(src_eof), .src_ready_o(src_ready), .fifo_push_o(push),
    .fifo_data_o(push_data), .thre_i(thre), .cts_i(cts), .dsr_i(dsr),
    .en_set_i(en_set), .en_clr_i(en_clr), .tx_en_o(tx_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // loads n bytes (plus optional eof beat); the first nexp are expected now
  task automatic load(input int n, input int nexp, input bit eof);
    for (int i = 0; i < n; i++) begin
      src_q.push_back({1'b0, seed});
      if (i < nexp) exp_q.push_back(seed);
      seed = seed + 8'd7;
    end
    if (eof) src_q.push_back({1'b1, 8'hEE});
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm;
    thre = 1'b0;
    cycles(2);
    thre = 1'b1;
  endtask

  task automatic pulse(input bit s, input bit c);
    en_set = s; en_clr = c;
    cycles(1);
    en_set = 1'b0; en_clr = 1'b0;
  endtask

  // source driver: the beat changes only after a completed handshake
  initial begin
    src_valid = 1'b0; src_data = '0; src_eof = 1'b0;
    forever begin
      @(negedge clk);
      hs = src_valid && src_ready;
      @(posedge clk);
      #1;
      if (hs && src_q.size() > 0) void'(src_q.pop_front());
      src_valid = (src_q.size() > 0);
      src_data  = src_valid ? src_q[0][7:0] : 8'h00;
      src_eof   = src_valid ? src_q[0][8] : 1'b0;
    end
  end

  // monitor: every push is compared with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && push) begin
        push_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected push", push_data, -1);
        else check(push_data == exp_q.pop_front(), "R10 data order", push_data, -2);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    thre = 1'b1; cts = 1'b0; dsr = 1'b1; en_set = 1'b0; en_clr = 1'b0;
    cycles(3);
    check(!src_ready && !push && !tx_en, "R9 reset outputs", {src_ready, push, tx_en}, 0);
    rst_n = 1'b1;
    load(20, 15, 1'b0);
    cts = 1'b1;
    cycles(10);
    check(push_cnt == 0, "R1 disabled no push", push_cnt, 0);
    check(src_q.size() == 20, "R1 disabled no take", src_q.size(), 20);
    cts = 1'b0;
    pulse(1'b1, 1'b0);
    cycles(1);
    check(tx_en == 1'b1, "R8 set", tx_en, 1);
    cycles(10);
    check(push_cnt == 0, "R2 cts low waits", push_cnt, 0);
    cts = 1'b1;  // R7: starts without a new THRE edge
    cycles(30);
    check(push_cnt == 15, "R3 burst limit", push_cnt, 15);
    check(src_q.size() == 5, "R3 remainder kept", src_q.size(), 5);
    check(!src_ready, "R10 ready low when idle", src_ready, 0);
    cycles(10);
    check(push_cnt == 15, "R6 no refill while THRE high", push_cnt, 15);
    exp_q.push_back(src_q[0][7:0]); exp_q.push_back(src_q[1][7:0]);
    exp_q.push_back(src_q[2][7:0]); exp_q.push_back(src_q[3][7:0]);
    exp_q.push_back(src_q[4][7:0]);
    rearm;
    cycles(20);
    check(push_cnt == 20, "R4 dry burst count", push_cnt, 20);
    check(!src_ready, "R4 burst ended", src_ready, 0);
    load(3, 3, 1'b1);
    rearm;
    cycles(20);
    check(push_cnt == 23, "R5 bytes before eof", push_cnt, 23);
    check(tx_en == 1'b0, "R5 eof disables", tx_en, 0);
    check(src_q.size() == 0, "R5 eof consumed", src_q.size(), 0);
    load(4, 0, 1'b0);
    rearm;
    cycles(15);
    check(push_cnt == 23, "R1 no burst after eof", push_cnt, 23);
    dsr = 1'b0;
    pulse(1'b1, 1'b0);
    cycles(10);
    check(push_cnt == 23, "R2 dsr low waits", push_cnt, 23);
    for (int i = 0; i < 4; i++) exp_q.push_back(src_q[i][7:0]);
    dsr = 1'b1;
    cycles(15);
    check(push_cnt == 27, "R7 poll start", push_cnt, 27);
    load(10, 10, 1'b0);
    rearm;
    while (push_cnt < 30) @(negedge clk);
    cts = 1'b0; dsr = 1'b0;
    cycles(20);
    check(push_cnt == 37, "R2 no recheck mid burst", push_cnt, 37);
    check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    cts = 1'b1; dsr = 1'b1;
    pulse(1'b1, 1'b1);
    cycles(1);
    check(tx_en == 1'b0, "R8 clear wins", tx_en, 0);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    cycles(1);
    check(tx_en == 1'b0, "R8 clear", tx_en, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule